// File: doc/BRIEF.md
# ADC Result Interrupt and Protection Controller

This block sits between an A/D conversion sequencer and the CPU side. Each time the sequencer reports a finished conversion, the block loads the 10-bit sample into a data register and raises a pending flag. When software has enabled it, a registered interrupt request goes to the interrupt controller under a fixed interrupt identifier.

An automatic transfer service (a DMA-style engine) can move results to memory. When this service mode is selected, each loaded sample also sets a hold output toward the sequencer. While hold is high, further done pulses are dropped, so the pending sample cannot be overwritten. A one-cycle acknowledge from the transfer engine reads the sample in that cycle. On the following clock edge it clears both the flag and the hold.

Software works through a four-bit control/status register with these fields:

| Bit | Field | Meaning |
|-----|-------|---------|
| 0 | flag | pending flag |
| 1 | enable | interrupt enable |
| 2 | short | 8-bit result mode |
| 3 | service | transfer-service mode |

Top module: `adc_result_irq_ctrl`

## Requirements
- R1: After a synchronous reset, flag, enable, short mode, service mode, hold and interrupt request are all 0, and the result reads 0.
- R2: A `conv_done` pulse while `conv_hold` is low loads `conv_result` into the data register and sets the flag (status bit 0) at that clock edge.
- R3: `irq_req` is high exactly when the flag and the enable bit (status bit 1) are both 1, updated at the same edge as either of them.
- R4: A register write with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves the flag unchanged.
- R5: When a load and a flag clear (by software write or by acknowledge) fall in the same cycle, the flag ends up set.
- R6: In service mode (status bit 3 = 1), a load raises `conv_hold`. While `conv_hold` is high, done pulses change neither the data register nor the flag.
- R7: `result_o` shows the pending sample during the `xfer_ack` cycle. At the next edge, the flag and `conv_hold` are 0, unless a load happens in that same cycle.
- R8: With short mode (status bit 2 = 1), `result_o` returns the upper 8 bits of the sample right-aligned, with bits 9:8 reading 0. Otherwise `result_o` returns all 10 bits.
- R9: `irq_id` always carries interrupt number 11.
- R10: With service mode off, `conv_hold` stays low and every done pulse overwrites the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle pulse: conversion finished |
| conv_result | input | 10 | Sample carried with `conv_done` |
| conv_hold | output | 1 | Sequencer must not start a conversion |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 4 | Write data: flag, enable, short, service |
| csr_rdata | output | 4 | Status: flag, enable, short, service |
| result_o | output | 10 | Data register, formatted by short mode |
| xfer_ack | input | 1 | One-cycle transfer-complete acknowledge |
| irq_req | output | 1 | Interrupt request |
| irq_id | output | 8 | Interrupt number |

## Verification
Flag, hold and interrupt request are registered. Each takes its new value at the clock edge that samples the causing input, so it is due one edge after the stimulus is driven. `result_o` and `csr_rdata` follow the registers combinationally. The bench drives inputs on the falling edge. Its reference model updates at the rising edge, and it compares every output at the next falling edge. Each check therefore looks at the first cycle in which a result is due, and that includes the acknowledge cycle, where the pending sample must still be visible.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int CSR_W        = 4;
  localparam int CSR_FLAG_BIT = 0;
  localparam int CSR_IEN_BIT  = 1;
  localparam int CSR_MODE_BIT = 2;
  localparam int CSR_SVC_BIT  = 3;
  localparam int IRQ_ID_W     = 8;
  localparam int IRQ_ID_DEF   = 11;

  typedef struct packed {
    logic svc;
    logic short_mode;
    logic ien;
    logic flag;
  } status_t;
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic wr_ien,
  input  logic wr_mode,
  input  logic wr_svc,
  output logic ien_q,
  output logic ien_d,
  output logic mode_q,
  output logic svc_q
);
  logic mode_d, svc_d;

  always_comb begin
    ien_d  = we ? wr_ien  : ien_q;
    mode_d = we ? wr_mode : mode_q;
    svc_d  = we ? wr_svc  : svc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 1'b0;
      mode_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      mode_q <= mode_d;
      svc_q  <= svc_d;
    end
  end

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(ien_q) && $stable(mode_q) && $stable(svc_q)));
endmodule

// File: rtl/adc_flag_stall.sv
module adc_flag_stall (
  input  logic clk,
  input  logic rst,
  input  logic conv_done,
  input  logic xfer_ack,
  input  logic sw_clr,
  input  logic svc_i,
  input  logic ien_d_i,
  output logic capture_o,
  output logic flag_q,
  output logic hold_q,
  output logic irq_q
);
  logic flag_d, hold_d;

  always_comb begin
    capture_o = conv_done && !hold_q;
    if (capture_o)              flag_d = 1'b1;
    else if (sw_clr || xfer_ack) flag_d = 1'b0;
    else                        flag_d = flag_q;
    if (capture_o && svc_i)     hold_d = 1'b1;
    else if (xfer_ack)          hold_d = 1'b0;
    else                        hold_d = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      hold_q <= hold_d;
      irq_q  <= flag_d && ien_d_i;
    end
  end

  assert_load_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !hold_q) |=> flag_q);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !hold_q && (sw_clr || xfer_ack)) |=> flag_q);
  assert_write_one_noop_R4: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !conv_done && !xfer_ack && !sw_clr) |=> !flag_q);
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_ack && !(conv_done && !hold_q)) |=> (!flag_q && !hold_q));
  assert_no_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (!svc_i && !hold_q) |=> !hold_q);
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic             hold_i,
  input  logic [RES_W-1:0] din,
  input  logic             short_mode_i,
  output logic [RES_W-1:0] data_o
);
  localparam int PAD_W = RES_W - SHORT_W;

  logic [RES_W-1:0] data_q;
  logic [RES_W-1:0] short_view;

  always_ff @(posedge clk) begin
    if (rst)            data_q <= '0;
    else if (capture_i) data_q <= din;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign short_view = {{PAD_W{1'b0}}, data_q[RES_W-1 -: SHORT_W]};
    end else begin : g_nopad
      assign short_view = data_q;
    end
  endgenerate

  assign data_o = short_mode_i ? short_view : data_q;

  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(data_q));
endmodule

// File: rtl/adc_result_irq_ctrl.sv
module adc_result_irq_ctrl
  import adc_irq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8,
  parameter int IRQ_NUM = IRQ_ID_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                conv_done,
  input  logic [RES_W-1:0]    conv_result,
  output logic                conv_hold,
  input  logic                csr_we,
  input  logic [CSR_W-1:0]    csr_wdata,
  output logic [CSR_W-1:0]    csr_rdata,
  output logic [RES_W-1:0]    result_o,
  input  logic                xfer_ack,
  output logic                irq_req,
  output logic [IRQ_ID_W-1:0] irq_id
);
  logic ien_q, ien_d, mode_q, svc_q;
  logic capture, flag_q, hold_q, irq_q;
  status_t st;

  adc_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .we(csr_we),
    .wr_ien(csr_wdata[CSR_IEN_BIT]), .wr_mode(csr_wdata[CSR_MODE_BIT]),
    .wr_svc(csr_wdata[CSR_SVC_BIT]),
    .ien_q(ien_q), .ien_d(ien_d), .mode_q(mode_q), .svc_q(svc_q)
  );

  adc_flag_stall u_flag (
    .clk(clk), .rst(rst), .conv_done(conv_done), .xfer_ack(xfer_ack),
    .sw_clr(csr_we && !csr_wdata[CSR_FLAG_BIT]), .svc_i(svc_q),
    .ien_d_i(ien_d), .capture_o(capture), .flag_q(flag_q),
    .hold_q(hold_q), .irq_q(irq_q)
  );

  adc_result_store #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_store (
    .clk(clk), .rst(rst), .capture_i(capture), .hold_i(hold_q),
    .din(conv_result), .short_mode_i(mode_q), .data_o(result_o)
  );

  always_comb begin
    st.flag       = flag_q;
    st.ien        = ien_q;
    st.short_mode = mode_q;
    st.svc        = svc_q;
  end

  assign csr_rdata = st;
  assign conv_hold = hold_q;
  assign irq_req   = irq_q;
  assign irq_id    = IRQ_ID_W'(IRQ_NUM);

  assert_irq_match_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req == (st.flag && st.ien));
  assert_irq_id_R9: assert property (@(posedge clk) irq_id == IRQ_ID_W'(IRQ_NUM));
endmodule

// File: tb/adc_result_irq_ctrl_tb_top.sv
module adc_result_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_done = 1'b0;
  logic [RW-1:0] conv_result = '0;
  logic csr_we = 1'b0;
  logic [3:0] csr_wdata = '0;
  logic xfer_ack = 1'b0;
  logic conv_hold, irq_req;
  logic [3:0] csr_rdata;
  logic [RW-1:0] result_o;
  logic [7:0] irq_id;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  logic m_flag, m_ien, m_mode, m_svc, m_hold, m_irq;
  logic [RW-1:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_result(conv_result),
    .conv_hold(conv_hold), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .result_o(result_o), .xfer_ack(xfer_ack),
    .irq_req(irq_req), .irq_id(irq_id)
  );

  function automatic logic [RW-1:0] fmt(input logic [RW-1:0] d, input logic short_m);
    return short_m ? {2'b00, d[9:2]} : d;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_flag = 0; m_ien = 0; m_mode = 0; m_svc = 0; m_hold = 0; m_irq = 0; m_data = '0;
  endtask

  task automatic model_step();
    logic set, clr;
    set = conv_done && !m_hold;
    clr = (csr_we && !csr_wdata[0]) || xfer_ack;
    if (set) m_data = conv_result;
    if (set) begin
      if (m_svc) m_hold = 1;
    end else if (xfer_ack) m_hold = 0;
    m_flag = set ? 1'b1 : (clr ? 1'b0 : m_flag);
    if (csr_we) begin
      m_ien = csr_wdata[1]; m_mode = csr_wdata[2]; m_svc = csr_wdata[3];
    end
    m_irq = m_flag && m_ien;
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2 flag"}, 32'(csr_rdata[0]), 32'(m_flag));
    check({tag, " R3 irq"}, 32'(irq_req), 32'(m_irq));
    check({tag, " R6 hold"}, 32'(conv_hold), 32'(m_hold));
    check({tag, " R8 result"}, 32'(result_o), 32'(fmt(m_data, m_mode)));
    check({tag, " R4 status"}, 32'(csr_rdata), 32'({m_svc, m_mode, m_ien, m_flag}));
  endtask

  task automatic cyc(input logic d, input logic [RW-1:0] r, input logic we,
                     input logic [3:0] wd, input logic ack, input string tag);
    conv_done = d; conv_result = r; csr_we = we; csr_wdata = wd; xfer_ack = ack;
    @(posedge clk);
    model_step();
    @(negedge clk);
    conv_done = 0; csr_we = 0; xfer_ack = 0;
    check_all(tag);
  endtask

  initial begin
    while (!done_flag) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 status", 32'(csr_rdata), 32'h0);
    check("R1 hold", 32'(conv_hold), 0);
    check("R1 irq", 32'(irq_req), 0);
    check("R1 result", 32'(result_o), 0);
    // R9 interrupt number
    check("R9 irq_id", 32'(irq_id), 11);
    // R2 load without enable
    cyc(1, 10'h2A5, 0, 4'h0, 0, "R2 load");
    check("R2 data", 32'(result_o), 32'h2A5);
    check("R3 irq off", 32'(irq_req), 0);
    // R3 enable -> irq; write flag bit 1 keeps flag (R4)
    cyc(0, '0, 1, 4'b0011, 0, "R3 enable");
    check("R3 irq on", 32'(irq_req), 1);
    check("R4 write1 keeps", 32'(csr_rdata[0]), 1);
    // R4 write 0 clears
    cyc(0, '0, 1, 4'b0010, 0, "R4 clear");
    check("R4 cleared", 32'(csr_rdata[0]), 0);
    check("R3 irq drop", 32'(irq_req), 0);
    // R4 write 1 on clear flag leaves it clear
    cyc(0, '0, 1, 4'b0011, 0, "R4 write1");
    check("R4 write1 clear", 32'(csr_rdata[0]), 0);
    // R5 set and clear together
    cyc(1, 10'h155, 1, 4'b0010, 0, "R5 sim");
    check("R5 set wins", 32'(csr_rdata[0]), 1);
    // R8 short mode
    cyc(0, '0, 1, 4'b0111, 0, "R8 short");
    check("R8 short view", 32'(result_o), 32'h055);
    cyc(0, '0, 1, 4'b0011, 0, "R8 long");
    check("R8 full view", 32'(result_o), 32'h155);
    // R10 no service mode: overwrite, no hold
    cyc(1, 10'h0F0, 0, 4'h0, 0, "R10 a");
    cyc(1, 10'h30F, 0, 4'h0, 0, "R10 b");
    check("R10 overwrite", 32'(result_o), 32'h30F);
    check("R10 no hold", 32'(conv_hold), 0);
    // R6 service mode stall
    cyc(0, '0, 1, 4'b1010, 0, "R6 svc on");
    cyc(1, 10'h1C3, 0, 4'h0, 0, "R6 load");
    check("R6 hold up", 32'(conv_hold), 1);
    cyc(0, '0, 1, 4'b1010, 0, "R6 swclr");
    cyc(1, 10'h3FF, 0, 4'h0, 0, "R6 drop");
    check("R6 kept data", 32'(result_o), 32'h1C3);
    check("R6 flag unchanged", 32'(csr_rdata[0]), 0);
    // R7 ack reads then releases
    conv_done = 1; conv_result = 10'h2EE; xfer_ack = 1;
    #1 check("R7 data in ack cycle", 32'(result_o), 32'h1C3);
    @(posedge clk); model_step(); @(negedge clk);
    conv_done = 0; xfer_ack = 0;
    check_all("R7 ack");
    check("R7 hold released", 32'(conv_hold), 0);
    check("R7 flag cleared", 32'(csr_rdata[0]), 0);
    check("R7 data kept", 32'(result_o), 32'h1C3);
    // R5 ack with load when not held: set wins
    cyc(1, 10'h011, 0, 4'h0, 1, "R5 ack+load");
    check("R5 flag set", 32'(csr_rdata[0]), 1);
    check("R6 hold re-armed", 32'(conv_hold), 1);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic d, we, ack;
      logic [3:0] wd;
      d = ($urandom % 100) < 35;
      we = ($urandom % 100) < 12;
      ack = ($urandom % 100) < 15;
      wd = 4'($urandom);
      cyc(d, RW'($urandom), we, wd, ack, "RND");
    end
    // R1 reset again mid-run
    rst = 1;
    @(posedge clk); model_reset(); @(negedge clk);
    rst = 0;
    check_all("R1 rerst");
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule